// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This unit collects event pulses from a UART datapath and turns them into one level-sensitive interrupt line. There are thirteen event sources. Each pulse sets a sticky bit in the interrupt status register. Software clears a status bit by writing a one to it. A mask decides which status bits may drive the interrupt line.

The mask cannot be written directly. One address ORs the written value into the mask. A second address clears the mask bits where the written value has ones. The unit also registers a live channel status word. Its lower ten bits mirror the current condition levels in the same order as the interrupt bits. Its upper five bits carry activity flags, and two of the conditions sit at different positions there than in the interrupt layout.

Software reaches the unit through a plain 32-bit register port. A read is requested with a strobe, and the data appears on the next cycle. Reads change no state.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted at a clock edge, the mask, the interrupt status and the read data all become zero, and the interrupt line is low.
- R2: A write to offset 0x08 ORs bits [12:0] of the write data into the mask.
- R3: A write to offset 0x0C clears every mask bit whose write-data bit is one. Other mask bits keep their value.
- R4: A write to the mask offset 0x10 leaves the mask unchanged. Reading 0x10 returns the mask in bits [12:0] and zeros above.
- R5: A one on `evt_pulse[i]` sets status bit i, and the bit stays set after the pulse ends. Bit order: 0 rx trigger, 1 rx empty, 2 rx full, 3 tx empty, 4 tx full, 5 rx overrun, 6 framing, 7 parity, 8 timeout, 9 modem status, 10 tx trigger, 11 tx nearly full, 12 tx overflow.
- R6: A write to the status offset 0x14 clears each status bit where the data has a one. Bits written with zero keep their value.
- R7: A read of any offset, including repeated reads of 0x14, leaves the mask and the status unchanged.
- R8: `irq` is high exactly when some bit is set in both the mask and the status. It follows a register change in the same cycle that the change becomes visible.
- R9: If an event pulse and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R10: The live word, read at offset 0x2C, is registered from the inputs one cycle before. Bits [9:0] are `cond_lvl[9:0]`, bit 10 is `rx_active`, bit 11 is `tx_active`, bit 12 is `flow_delay`, bit 13 is `cond_lvl[10]` and bit 14 is `cond_lvl[11]`. Bits above 14 are zero.
- R11: Reads of any other offset, including 0x08 and 0x0C, return zero. Writes to 0x2C or to unmapped offsets change neither the mask nor the status.
- R12: `bus_rdata` is loaded only in a cycle where `bus_rd` is high. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid on the next cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 13 | One-cycle event pulses, one per interrupt source |
| cond_lvl | input | 13 | Current condition levels for the live status word |
| rx_active | input | 1 | Receiver busy flag |
| tx_active | input | 1 | Transmitter busy flag |
| flow_delay | input | 1 | Flow-delay condition flag |
| irq | output | 1 | Level interrupt output |

## Verification
Each source is pulsed on its own and then cleared. This shows that every pulse sets its own status bit, so a swapped bit would be caught. Overlapping masks are built with set and clear writes, and pulses are sent both inside and outside the mask. This separates an OR from a plain load, and it shows whether the interrupt line really uses the mask. A clear is timed onto the same edge as a pulse on that bit to check which one wins. The live word is read with walking and all-ones patterns on the condition and flag inputs, which exposes any misplaced upper bit. A reference model is compared against the outputs on every clock throughout.

// File: rtl/uart_irq_pkg.sv
// Package: shared widths, register offsets and source indices for the
// UART interrupt mask and status unit.
package uart_irq_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NSRC      = 13;   // interrupt sources
    localparam int SHARED_LO = 10;   // low live bits that mirror the irq layout
    localparam int LIVE_W    = SHARED_LO + 5;

    // Register byte offsets
    localparam int OFS_MASK_SET = 'h08;
    localparam int OFS_MASK_CLR = 'h0C;
    localparam int OFS_MASK     = 'h10;
    localparam int OFS_STAT     = 'h14;
    localparam int OFS_LIVE     = 'h2C;

    // Interrupt source positions (order is visible to software)
    typedef enum int {
        SRC_RX_TRIG   = 0,
        SRC_RX_EMPTY  = 1,
        SRC_RX_FULL   = 2,
        SRC_TX_EMPTY  = 3,
        SRC_TX_FULL   = 4,
        SRC_RX_OVR    = 5,
        SRC_FRAMING   = 6,
        SRC_PARITY    = 7,
        SRC_TIMEOUT   = 8,
        SRC_MODEM     = 9,
        SRC_TX_TRIG   = 10,
        SRC_TX_NFULL  = 11,
        SRC_TX_OVR    = 12
    } irq_src_e;
endpackage

// File: rtl/irq_mask_reg.sv
// Interrupt mask held behind set-only and clear-only write ports.
// Assumes set_en and clr_en are never high together (distinct offsets).
module irq_mask_reg #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask_q
);
    // Mask update: OR on set writes, AND-NOT on clear writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (set_en) begin
            mask_q <= mask_q | wdata;
        end else if (clr_en) begin
            mask_q <= mask_q & ~wdata;
        end
    end
endmodule

// File: rtl/irq_status_reg.sv
// Sticky interrupt status. An event pulse sets a bit and a write-one clear
// resets it. When both hit one bit in the same cycle, the event wins.
// Assumes evt is a single-cycle pulse per occurrence.
module irq_status_reg #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] evt,
    output logic [N-1:0] stat_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit sticky flag with set priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[i] <= 1'b0;
            end else if (evt[i]) begin
                stat_q[i] <= 1'b1;
            end else if (clr_en && wdata[i]) begin
                stat_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/live_status_reg.sv
// Registered live channel status word. The low bits mirror the condition
// levels. The upper bits carry activity flags and the two transmit
// conditions at moved positions. Assumes the fixed layout from uart_irq_pkg.
module live_status_reg
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   cond_lvl,
    input  logic              rx_active,
    input  logic              tx_active,
    input  logic              flow_delay,
    output logic [LIVE_W-1:0] live_q
);
    logic [LIVE_W-1:0] live_d;
    logic              unused_ovr;

    assign unused_ovr = cond_lvl[SRC_TX_OVR];

    for (genvar i = 0; i < SHARED_LO; i++) begin : g_low
        assign live_d[i] = cond_lvl[i];
    end
    assign live_d[SHARED_LO]     = rx_active;
    assign live_d[SHARED_LO + 1] = tx_active;
    assign live_d[SHARED_LO + 2] = flow_delay;
    assign live_d[SHARED_LO + 3] = cond_lvl[SRC_TX_TRIG];
    assign live_d[SHARED_LO + 4] = cond_lvl[SRC_TX_NFULL];

    // Capture the assembled word once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// Top of the UART interrupt mask and status unit. It decodes the register
// port, holds the mask, the sticky status and the live word, returns read
// data one cycle after bus_rd, and drives the level interrupt.
// Assumes a single access per cycle and byte offsets on bus_addr.
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   evt_pulse,
    input  logic [NSRC-1:0]   cond_lvl,
    input  logic              rx_active,
    input  logic              tx_active,
    input  logic              flow_delay,
    output logic              irq
);
    logic [NSRC-1:0]   mask_q;
    logic [NSRC-1:0]   stat_q;
    logic [LIVE_W-1:0] live_q;
    logic [DATA_W-1:0] rd_mux;
    logic              hit_set, hit_clr, hit_stat;
    logic              unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:NSRC];

    assign hit_set  = bus_wr && (bus_addr == ADDR_W'(OFS_MASK_SET));
    assign hit_clr  = bus_wr && (bus_addr == ADDR_W'(OFS_MASK_CLR));
    assign hit_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));

    irq_mask_reg #(.N(NSRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (hit_set),
        .clr_en (hit_clr),
        .wdata  (bus_wdata[NSRC-1:0]),
        .mask_q (mask_q)
    );

    irq_status_reg #(.N(NSRC)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_en (hit_stat),
        .wdata  (bus_wdata[NSRC-1:0]),
        .evt    (evt_pulse),
        .stat_q (stat_q)
    );

    live_status_reg u_live (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_lvl   (cond_lvl),
        .rx_active  (rx_active),
        .tx_active  (tx_active),
        .flow_delay (flow_delay),
        .live_q     (live_q)
    );

    // Read selection by offset; unmapped and write-only offsets give zero
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(OFS_MASK))      rd_mux[NSRC-1:0]   = mask_q;
        else if (bus_addr == ADDR_W'(OFS_STAT)) rd_mux[NSRC-1:0]   = stat_q;
        else if (bus_addr == ADDR_W'(OFS_LIVE)) rd_mux[LIVE_W-1:0] = live_q;
    end

    // Read data register, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // Level interrupt from enabled pending sources
    assign irq = |(mask_q & stat_q);
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Checker for uart_irq_ctrl, attached by bind. It watches the bus port,
// the event pulses and the mask and status registers.
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSRC-1:0]   wdata,
    input logic [NSRC-1:0]   evt_pulse,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   stat_q,
    input logic              irq
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && stat_q == '0));

    assert_set_ors_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_MASK_SET))
        |=> ((mask_q & $past(wdata)) == $past(wdata)));

    assert_clr_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_MASK_CLR))
        |=> ((mask_q & $past(wdata)) == '0));

    assert_mask_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_MASK)) |=> $stable(mask_q));

    assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && evt_pulse == '0)
        |=> ((stat_q & $past(wdata)) == '0));

    assert_no_pending_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wdata     (bus_wdata[uart_irq_pkg::NSRC-1:0]),
    .evt_pulse (evt_pulse),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .irq       (irq)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [12:0] evt_pulse = '0, cond_lvl = '0;
    logic        rx_active = 1'b0, tx_active = 1'b0, flow_delay = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit model_on = 0;
    string cur_req = "R1";

    // Reference model state
    int unsigned m_mask = 0, m_stat = 0, m_live = 0, m_rd = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    uart_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .cond_lvl(cond_lvl), .rx_active(rx_active),
        .tx_active(tx_active), .flow_delay(flow_delay), .irq(irq)
    );

    function automatic int unsigned live_of();
        int unsigned v;
        v = cond_lvl & 'h3FF;
        if (rx_active)   v |= 1 << 10;
        if (tx_active)   v |= 1 << 11;
        if (flow_delay)  v |= 1 << 12;
        if (cond_lvl[10]) v |= 1 << 13;
        if (cond_lvl[11]) v |= 1 << 14;
        return v;
    endfunction

    // Behavioural model advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 0; m_stat = 0; m_live = 0; m_rd = 0;
        end else begin
            if (bus_rd) begin
                case (bus_addr)
                    8'h10:   m_rd = m_mask;
                    8'h14:   m_rd = m_stat;
                    8'h2C:   m_rd = m_live;
                    default: m_rd = 0;
                endcase
            end
            if (bus_wr && bus_addr == 8'h08) m_mask |= bus_wdata & 'h1FFF;
            if (bus_wr && bus_addr == 8'h0C) m_mask &= ~bus_wdata;
            if (bus_wr && bus_addr == 8'h14) m_stat &= ~bus_wdata;
            m_stat |= evt_pulse;
            m_live = live_of();
        end
    end

    task automatic check(string req, int unsigned act, int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            check({cur_req, "/R8 irq"}, irq, ((m_mask & m_stat) != 0));
            check({cur_req, "/R12 rdata"}, bus_rdata, m_rd);
        end
    end

    task automatic wr(logic [7:0] a, int unsigned d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, int unsigned exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(logic [12:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        #(5 * 20000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq", irq, 0);
        check("R1 rdata", bus_rdata, 0);
        rst_n = 1'b1;
        model_on = 1;
        rd_chk("R1 mask", 8'h10, 0);
        rd_chk("R1 stat", 8'h14, 0);

        cur_req = "R2";
        wr(8'h08, 'h005); wr(8'h08, 'h100);
        rd_chk("R2", 8'h10, 'h105);
        cur_req = "R3";
        wr(8'h0C, 'h004);
        rd_chk("R3", 8'h10, 'h101);
        cur_req = "R4";
        wr(8'h10, 'h1FFF);
        rd_chk("R4", 8'h10, 'h101);

        cur_req = "R5";
        pulse(13'h008);
        repeat (3) @(negedge clk);
        rd_chk("R5 sticky", 8'h14, 'h008);
        check("R8 masked-out", irq, 0);
        pulse(13'h001);
        check("R8 enabled", irq, 1);
        cur_req = "R7";
        rd_chk("R7 first", 8'h14, 'h009);
        rd_chk("R7 second", 8'h14, 'h009);
        cur_req = "R6";
        wr(8'h14, 'h001);
        rd_chk("R6", 8'h14, 'h008);
        check("R6 irq", irq, 0);

        cur_req = "R9";
        @(negedge clk);
        evt_pulse = 13'h008; bus_addr = 8'h14; bus_wdata = 'h008; bus_wr = 1'b1;
        @(negedge clk);
        evt_pulse = '0; bus_wr = 1'b0;
        rd_chk("R9", 8'h14, 'h008);
        wr(8'h14, 'h1FFF);

        cur_req = "R5";
        for (int i = 0; i < 13; i++) begin
            pulse(13'(1 << i));
            rd_chk("R5 bit order", 8'h14, 1 << i);
            wr(8'h14, 1 << i);
        end
        rd_chk("R6 all cleared", 8'h14, 0);

        cur_req = "R10";
        cond_lvl = 13'h1FFF;
        rd_chk("R10 conds", 8'h2C, 'h63FF);
        cond_lvl = 13'h0400; rx_active = 1'b1;
        rd_chk("R10 rx/txtrig", 8'h2C, 'h2400);
        cond_lvl = 13'h0800; rx_active = 1'b0; tx_active = 1'b1; flow_delay = 1'b1;
        rd_chk("R10 tx/fd/nfull", 8'h2C, 'h5800);
        cond_lvl = 13'h1000; tx_active = 1'b0; flow_delay = 1'b0;
        rd_chk("R10 ovr absent", 8'h2C, 0);

        cur_req = "R11";
        wr(8'h08, 'h1FFF);
        pulse(13'h0A5);
        rd_chk("R11 mask-set reads 0", 8'h08, 0);
        rd_chk("R11 mask-clr reads 0", 8'h0C, 0);
        rd_chk("R11 unmapped", 8'h30, 0);
        wr(8'h2C, 'h1FFF); wr(8'h00, 'h1FFF); wr(8'h18, 'h1FFF);
        rd_chk("R11 mask kept", 8'h10, 'h1FFF);
        rd_chk("R11 stat kept", 8'h14, 'h0A5);
        check("R8 irq on", irq, 1);

        cur_req = "R12";
        rd_chk("R12 load", 8'h10, 'h1FFF);
        @(negedge clk); bus_addr = 8'h14;
        @(negedge clk);
        check("R12 hold", bus_rdata, 'h1FFF);

        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq after reset", irq, 0);
        check("R1 rdata after reset", bus_rdata, 0);
        rst_n = 1'b1;
        rd_chk("R1 mask after reset", 8'h10, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule